// File: doc/BRIEF.md
# Coherent Bus Transaction Sequencer

This block is the shared-bus side of a snooping coherence scheme. Several cache controllers raise requests toward it. It grants the bus to one of them at a time, in round-robin order. It broadcasts that requester's read or write command and address to every snooper, then waits a fixed number of cycles for the snoopers to drive their shared and dirty response lines. At the end of that window it samples the lines, ignores the requester's own pair, and decides where the line comes from: a cache that holds a modified copy, or main memory.

When the data comes from a cache, the same data and address are also written back to memory. When memory supplies the line, the block issues a read and captures the data after a fixed memory latency. It then returns the data, a fill state and a source flag to the requester with a one-cycle acknowledge. A write request is treated as a read-for-ownership. The broadcast carries an invalidate, and the requester always receives a modified fill.

Top module: `snp_bus_ctrl`

## Requirements
- R1: Arbitration is round-robin. After requester i has been acknowledged, the search for the next winner starts at i+1 and wraps modulo N. The grant is one-hot and stays fixed from the cycle after the request is taken until the acknowledge cycle, both included.
- R2: The cycle after a grant is issued, bus_cmd_valid is high for exactly one cycle. In that cycle bus_addr and bus_cmd_write carry the winner's address and write flag.
- R3: The snoop lines are sampled in the SNOOP_WIN-th cycle after the broadcast cycle. The shared and dirty lines of the requester itself are ignored.
- R4: If any other snooper asserts dirty, that cache's data is returned and fill_from_cache is 1. In the acknowledge cycle, mem_wr is high with mem_wdata equal to the returned data. The acknowledge comes SNOOP_WIN+1 cycles after the broadcast.
- R5: For a read where shared is seen and dirty is not, memory supplies the data and the fill state is shared. Fill state encoding: 0 invalid, 1 shared, 2 exclusive, 3 modified.
- R6: For a read where neither line is seen, memory supplies the data and the fill state is exclusive (2).
- R7: If several snoopers assert dirty, the lowest-numbered one that is not the requester supplies the data.
- R8: A write request broadcasts with bus_inval high in the command cycle, and it is always acknowledged with fill state modified (3). The data source follows R4 to R7.
- R9: On the memory path, mem_rd pulses for one cycle, mem_rdata is captured MEM_LAT cycles later, and the acknowledge comes SNOOP_WIN+MEM_LAT+2 cycles after the broadcast. mem_wr stays low.
- R10: ack is high for exactly one cycle and equals the grant. After reset, grant, ack and bus_cmd_valid are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_REQ | Per-requester request, held until ack |
| req_write | input | N_REQ | Per-requester write (ownership) flag |
| req_addr | input | N_REQ*ADDR_W | Per-requester line address |
| grant | output | N_REQ | One-hot bus owner |
| bus_cmd_valid | output | 1 | Command broadcast strobe |
| bus_cmd_write | output | 1 | Broadcast command is a write |
| bus_inval | output | 1 | Invalidate indication to snoopers |
| bus_addr | output | ADDR_W | Broadcast address, held for the transaction |
| snp_shared | input | N_REQ | Per-snooper shared line |
| snp_dirty | input | N_REQ | Per-snooper dirty line |
| snp_data | input | N_REQ*DATA_W | Per-snooper supplied data |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory writeback strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Writeback data |
| mem_rdata | input | DATA_W | Memory read data, valid MEM_LAT cycles after mem_rd |
| ack | output | N_REQ | One-hot completion acknowledge |
| fill_data | output | DATA_W | Line data for the requester |
| fill_state | output | 2 | Fill state code |
| fill_from_cache | output | 1 | 1 when a cache supplied the data |

## Verification
The bench builds the block with four requesters, a snoop window of 2 and a memory latency of 3. With these values the two paths end 3 and 7 cycles after the broadcast, so a window or latency miscount moves the acknowledge by a cycle that the bench sees. Four requesters make room for two dirty responders besides the requester, which exercises the priority pick. They also allow three requests at once from a non-zero pointer, so the round-robin order visibly wraps past the highest index.

// File: rtl/snp_pkg.sv
package snp_pkg;
    typedef enum logic [1:0] {
        FILL_INV = 2'd0,
        FILL_SHR = 2'd1,
        FILL_EXC = 2'd2,
        FILL_MOD = 2'd3
    } fill_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_REQ,
        PH_SNOOP,
        PH_MEM,
        PH_DONE
    } phase_e;

    function automatic fill_e pick_fill(input logic wr, input logic sh, input logic dt);
        if (wr)
            return FILL_MOD;
        else if (sh || dt)
            return FILL_SHR;
        else
            return FILL_EXC;
    endfunction
endpackage

// File: rtl/snp_rr_arb.sv
module snp_rr_arb #(
    parameter int N_REQ = 4,
    localparam int IW = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_REQ-1:0] req,
    input  logic             advance,
    input  logic [IW-1:0]    done_idx,
    output logic             any,
    output logic [IW-1:0]    idx
);
    logic [IW-1:0] ptr;

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int off = N_REQ - 1; off >= 0; off--) begin
            int cand;
            cand = (int'(ptr) + off) % N_REQ;
            if (req[cand]) begin
                any = 1'b1;
                idx = IW'(cand);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (advance)
            ptr <= (int'(done_idx) == N_REQ - 1) ? '0 : done_idx + IW'(1);
    end

    p_win_requests_r1: assert property (@(posedge clk) disable iff (rst)
        any |-> req[idx]);
endmodule

// File: rtl/snp_resolve.sv
module snp_resolve #(
    parameter int N_REQ  = 4,
    parameter int DATA_W = 32
) (
    input  logic [N_REQ-1:0]        owner,
    input  logic [N_REQ-1:0]        shared_in,
    input  logic [N_REQ-1:0]        dirty_in,
    input  logic [N_REQ*DATA_W-1:0] data_in,
    output logic                    any_shared,
    output logic                    any_dirty,
    output logic [DATA_W-1:0]       src_data
);
    logic [N_REQ-1:0] sh_m, dt_m;

    assign sh_m       = shared_in & ~owner;
    assign dt_m       = dirty_in & ~owner;
    assign any_shared = |sh_m;
    assign any_dirty  = |dt_m;

    always_comb begin
        src_data = '0;
        for (int k = N_REQ - 1; k >= 0; k--) begin
            if (dt_m[k])
                src_data = data_in[k*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/snp_seq.sv
module snp_seq
    import snp_pkg::*;
#(
    parameter int N_REQ     = 4,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int SNOOP_WIN = 2,
    parameter int MEM_LAT   = 3,
    localparam int IW   = (N_REQ > 1) ? $clog2(N_REQ) : 1,
    localparam int CMAX = (SNOOP_WIN > MEM_LAT) ? SNOOP_WIN : MEM_LAT,
    localparam int CW   = $clog2(CMAX + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    arb_any,
    input  logic [IW-1:0]           arb_idx,
    input  logic [N_REQ-1:0]        req_write,
    input  logic [N_REQ*ADDR_W-1:0] req_addr,
    input  logic                    res_shared,
    input  logic                    res_dirty,
    input  logic [DATA_W-1:0]       res_data,
    input  logic [DATA_W-1:0]       mem_rdata,
    output logic [N_REQ-1:0]        grant_oh,
    output logic                    advance,
    output logic [IW-1:0]           own_idx,
    output logic                    bus_cmd_valid,
    output logic                    bus_cmd_write,
    output logic                    bus_inval,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic                    mem_rd,
    output logic                    mem_wr,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    output logic [N_REQ-1:0]        ack,
    output logic [DATA_W-1:0]       fill_data,
    output fill_e                   fill_state,
    output logic                    fill_from_cache
);
    phase_e            phase;
    logic [CW-1:0]     cnt;
    logic              own_wr;
    logic [ADDR_W-1:0] own_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase           <= PH_IDLE;
            cnt             <= '0;
            own_idx         <= '0;
            own_wr          <= 1'b0;
            own_addr        <= '0;
            fill_data       <= '0;
            fill_state      <= FILL_INV;
            fill_from_cache <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (arb_any) begin
                        own_idx  <= arb_idx;
                        own_wr   <= req_write[arb_idx];
                        own_addr <= req_addr[arb_idx*ADDR_W +: ADDR_W];
                        phase    <= PH_REQ;
                    end
                end
                PH_REQ: begin
                    cnt   <= '0;
                    phase <= PH_SNOOP;
                end
                PH_SNOOP: begin
                    if (cnt == CW'(SNOOP_WIN - 1)) begin
                        fill_state <= pick_fill(own_wr, res_shared, res_dirty);
                        cnt        <= '0;
                        if (res_dirty) begin
                            fill_data       <= res_data;
                            fill_from_cache <= 1'b1;
                            phase           <= PH_DONE;
                        end else begin
                            fill_from_cache <= 1'b0;
                            phase           <= PH_MEM;
                        end
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                PH_MEM: begin
                    if (cnt == CW'(MEM_LAT)) begin
                        fill_data <= mem_rdata;
                        phase     <= PH_DONE;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                PH_DONE: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        grant_oh = '0;
        if (phase != PH_IDLE)
            grant_oh[own_idx] = 1'b1;
    end

    assign advance       = (phase == PH_DONE);
    assign ack           = advance ? grant_oh : '0;
    assign bus_cmd_valid = (phase == PH_REQ);
    assign bus_cmd_write = own_wr;
    assign bus_inval     = bus_cmd_valid & own_wr;
    assign bus_addr      = own_addr;
    assign mem_addr      = own_addr;
    assign mem_rd        = (phase == PH_MEM) && (cnt == '0);
    assign mem_wr        = advance & fill_from_cache;
    assign mem_wdata     = fill_data;

    p_grant_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_oh));
    p_grant_held_r1: assert property (@(posedge clk) disable iff (rst)
        (grant_oh != '0 && ack == '0) |=> grant_oh == $past(grant_oh));
    p_cmd_single_r2: assert property (@(posedge clk) disable iff (rst)
        bus_cmd_valid |=> !bus_cmd_valid);
    p_wb_on_ack_r4: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (ack != '0));
    p_rfo_modified_r8: assert property (@(posedge clk) disable iff (rst)
        ((ack != '0) && own_wr) |-> fill_state == FILL_MOD);
    p_memrd_single_r9: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);
    p_ack_single_r10: assert property (@(posedge clk) disable iff (rst)
        (ack != '0) |=> ack == '0);
endmodule

// File: rtl/snp_bus_ctrl.sv
module snp_bus_ctrl
    import snp_pkg::*;
#(
    parameter int N_REQ     = 4,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int SNOOP_WIN = 2,
    parameter int MEM_LAT   = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_REQ-1:0]        req_valid,
    input  logic [N_REQ-1:0]        req_write,
    input  logic [N_REQ*ADDR_W-1:0] req_addr,
    output logic [N_REQ-1:0]        grant,
    output logic                    bus_cmd_valid,
    output logic                    bus_cmd_write,
    output logic                    bus_inval,
    output logic [ADDR_W-1:0]       bus_addr,
    input  logic [N_REQ-1:0]        snp_shared,
    input  logic [N_REQ-1:0]        snp_dirty,
    input  logic [N_REQ*DATA_W-1:0] snp_data,
    output logic                    mem_rd,
    output logic                    mem_wr,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    input  logic [DATA_W-1:0]       mem_rdata,
    output logic [N_REQ-1:0]        ack,
    output logic [DATA_W-1:0]       fill_data,
    output logic [1:0]              fill_state,
    output logic                    fill_from_cache
);
    localparam int IW = (N_REQ > 1) ? $clog2(N_REQ) : 1;

    logic              arb_any, advance, res_shared, res_dirty;
    logic [IW-1:0]     arb_idx, own_idx;
    logic [DATA_W-1:0] res_data;
    fill_e             fstate;

    snp_rr_arb #(.N_REQ(N_REQ)) u_arb (
        .clk      (clk),
        .rst      (rst),
        .req      (req_valid),
        .advance  (advance),
        .done_idx (own_idx),
        .any      (arb_any),
        .idx      (arb_idx)
    );

    snp_resolve #(.N_REQ(N_REQ), .DATA_W(DATA_W)) u_res (
        .owner      (grant),
        .shared_in  (snp_shared),
        .dirty_in   (snp_dirty),
        .data_in    (snp_data),
        .any_shared (res_shared),
        .any_dirty  (res_dirty),
        .src_data   (res_data)
    );

    snp_seq #(
        .N_REQ(N_REQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .SNOOP_WIN(SNOOP_WIN), .MEM_LAT(MEM_LAT)
    ) u_seq (
        .clk             (clk),
        .rst             (rst),
        .arb_any         (arb_any),
        .arb_idx         (arb_idx),
        .req_write       (req_write),
        .req_addr        (req_addr),
        .res_shared      (res_shared),
        .res_dirty       (res_dirty),
        .res_data        (res_data),
        .mem_rdata       (mem_rdata),
        .grant_oh        (grant),
        .advance         (advance),
        .own_idx         (own_idx),
        .bus_cmd_valid   (bus_cmd_valid),
        .bus_cmd_write   (bus_cmd_write),
        .bus_inval       (bus_inval),
        .bus_addr        (bus_addr),
        .mem_rd          (mem_rd),
        .mem_wr          (mem_wr),
        .mem_addr        (mem_addr),
        .mem_wdata       (mem_wdata),
        .ack             (ack),
        .fill_data       (fill_data),
        .fill_state      (fstate),
        .fill_from_cache (fill_from_cache)
    );

    assign fill_state = fstate;

    p_ack_is_grant_r10: assert property (@(posedge clk) disable iff (rst)
        (ack != '0) |-> ack == grant);
    p_cache_src_dirty_r4: assert property (@(posedge clk) disable iff (rst)
        ((ack != '0) && fill_from_cache) |-> mem_wr && (mem_wdata == fill_data));
endmodule

// File: tb/tb_snp_bus_ctrl.sv
module tb_snp_bus_ctrl;
    import snp_pkg::*;

    localparam int N = 4;
    localparam int A = 16;
    localparam int D = 32;
    localparam int W = 2;
    localparam int L = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [N-1:0]   req_valid = '0, req_write = '0;
    logic [N*A-1:0] req_addr = '0;
    logic [N-1:0]   grant, ack, snp_shared = '0, snp_dirty = '0;
    logic           bus_cmd_valid, bus_cmd_write, bus_inval, mem_rd, mem_wr, fill_from_cache;
    logic [A-1:0]   bus_addr, mem_addr;
    logic [N*D-1:0] snp_data;
    logic [D-1:0]   mem_wdata, mem_rdata, fill_data;
    logic [1:0]     fill_state;

    function automatic logic [D-1:0] mem_val(input logic [A-1:0] a);
        return 32'hA500_0000 ^ {16'h0, a} ^ 32'h0001_0203;
    endfunction
    function automatic logic [D-1:0] cache_val(input int k, input logic [A-1:0] a);
        return {8'(k + 1), 8'hCC, a};
    endfunction

    for (genvar k = 0; k < N; k++) begin : g_snp
        assign snp_data[k*D +: D] = cache_val(k, bus_addr);
    end
    assign mem_rdata = mem_val(mem_addr);

    snp_bus_ctrl #(.N_REQ(N), .ADDR_W(A), .DATA_W(D), .SNOOP_WIN(W), .MEM_LAT(L)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .grant(grant), .bus_cmd_valid(bus_cmd_valid), .bus_cmd_write(bus_cmd_write),
        .bus_inval(bus_inval), .bus_addr(bus_addr), .snp_shared(snp_shared),
        .snp_dirty(snp_dirty), .snp_data(snp_data), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ack(ack),
        .fill_data(fill_data), .fill_state(fill_state), .fill_from_cache(fill_from_cache)
    );

    typedef struct {
        int           idx;
        logic         wr;
        logic [A-1:0] addr;
        logic [D-1:0] data;
        logic [1:0]   st;
        logic         fc;
        int           lat;
        string        tag;
    } exp_t;

    exp_t q[$];
    int   n_tests = 0, n_fail = 0;
    int   cyc = 0, cmd_cyc = 0, last_win = -1;
    bit   finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    function automatic exp_t make_exp(input int idx, input logic wr, input logic [A-1:0] addr,
                                      input logic [N-1:0] sh, input logic [N-1:0] dt, input string tag);
        exp_t e;
        logic [N-1:0] dm, sm;
        int w;
        dm = dt & ~(N'(1) << idx);
        sm = sh & ~(N'(1) << idx);
        e.idx = idx; e.wr = wr; e.addr = addr; e.tag = tag;
        if (dm != '0) begin
            w = -1;
            for (int k = N - 1; k >= 0; k--) if (dm[k]) w = k;
            e.data = cache_val(w, addr);
            e.fc   = 1'b1;
            e.st   = wr ? 2'd3 : 2'd1;
            e.lat  = W + 1;
        end else begin
            e.data = mem_val(addr);
            e.fc   = 1'b0;
            e.st   = wr ? 2'd3 : (sm != '0 ? 2'd1 : 2'd2);
            e.lat  = W + 2 + L;
        end
        return e;
    endfunction

    task automatic wait_acks(input int n);
        int got = 0;
        while (got < n) begin
            @(negedge clk);
            if (ack != '0) begin
                got++;
                req_valid = req_valid & ~ack;
            end
        end
    endtask

    task automatic run_one(input int idx, input logic wr, input logic [A-1:0] addr,
                           input logic [N-1:0] sh, input logic [N-1:0] dt, input string tag);
        @(negedge clk);
        snp_shared = sh;
        snp_dirty  = dt;
        q.push_back(make_exp(idx, wr, addr, sh, dt, tag));
        req_addr[idx*A +: A] = addr;
        req_write[idx] = wr;
        req_valid[idx] = 1'b1;
        wait_acks(1);
        last_win = idx;
    endtask

    // monitor: compares design results against the queued expectations
    always @(negedge clk) begin
        if (!rst && bus_cmd_valid) begin
            cmd_cyc = cyc;
            if (q.size() == 0) chk(0, "R2 unexpected command", 1, 0);
            else begin
                chk(bus_addr == q[0].addr, {q[0].tag, " R2 bus_addr"}, 64'(bus_addr), 64'(q[0].addr));
                chk(bus_cmd_write == q[0].wr, {q[0].tag, " R2 cmd_write"}, 64'(bus_cmd_write), 64'(q[0].wr));
                chk(bus_inval == q[0].wr, {q[0].tag, " R8 inval"}, 64'(bus_inval), 64'(q[0].wr));
                chk(grant == (N'(1) << q[0].idx), {q[0].tag, " R1 grant"}, 64'(grant), 64'(N'(1) << q[0].idx));
            end
        end
        if (!rst && ack != '0) begin
            if (q.size() == 0) chk(0, "R10 unexpected ack", 64'(ack), 0);
            else begin
                exp_t e;
                e = q.pop_front();
                chk(ack == (N'(1) << e.idx), {e.tag, " R10 ack"}, 64'(ack), 64'(N'(1) << e.idx));
                chk(fill_data == e.data, {e.tag, " data"}, 64'(fill_data), 64'(e.data));
                chk(fill_state == e.st, {e.tag, " state"}, 64'(fill_state), 64'(e.st));
                chk(fill_from_cache == e.fc, {e.tag, " source"}, 64'(fill_from_cache), 64'(e.fc));
                chk(cyc - cmd_cyc == e.lat, {e.tag, " R9 latency"}, 64'(cyc - cmd_cyc), 64'(e.lat));
                chk(mem_wr == e.fc, {e.tag, " R4 mem_wr"}, 64'(mem_wr), 64'(e.fc));
                if (e.fc)
                    chk(mem_wdata == e.data, {e.tag, " R4 wdata"}, 64'(mem_wdata), 64'(e.data));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(grant == '0, "R10 reset grant", 64'(grant), 0);
        chk(ack == '0, "R10 reset ack", 64'(ack), 0);
        chk(bus_cmd_valid == 1'b0, "R10 reset cmd", 64'(bus_cmd_valid), 0);

        run_one(0, 1'b0, 16'h1000, 4'b0000, 4'b0000, "R6 exclusive");
        run_one(1, 1'b0, 16'h2044, 4'b0100, 4'b0000, "R5 shared");
        run_one(2, 1'b0, 16'h3088, 4'b0000, 4'b1000, "R4 dirty");
        run_one(0, 1'b0, 16'h40C0, 4'b0100, 4'b1010, "R7 priority");
        run_one(1, 1'b0, 16'h5100, 4'b0010, 4'b0010, "R3 own lines");
        run_one(3, 1'b1, 16'h6140, 4'b0000, 4'b0001, "R8 rfo dirty");
        run_one(2, 1'b1, 16'h7180, 4'b0010, 4'b0000, "R8 rfo memory");

        // R1: three requests at once, pointer starts after requester 2
        begin
            int order[$];
            int set[N];
            set = '{1, 1, 0, 1};
            for (int off = 1; off <= N; off++) begin
                int c;
                c = (last_win + off) % N;
                if (set[c] == 1) order.push_back(c);
            end
            @(negedge clk);
            snp_shared = '0;
            snp_dirty  = '0;
            foreach (order[i]) begin
                logic [A-1:0] a;
                a = A'(16'h8000 + order[i] * 16'h40);
                q.push_back(make_exp(order[i], 1'b0, a, '0, '0, "R1 round robin"));
                req_addr[order[i]*A +: A] = a;
                req_write[order[i]] = 1'b0;
            end
            req_valid = 4'b1011;
            wait_acks(3);
        end

        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R1 all served", 64'(q.size()), 0);
        summary();
    end
endmodule